// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block holds the execution and addressing mode of a processor that runs in one of three modes: a user mode (Slave), a supervisor mode that forms addresses through segment appending (Master), and a privileged mode that forms addresses directly (Absolute). Every cycle it receives what the decoder knows about the instruction being executed: a valid strobe, a privileged-opcode flag, a transfer flag and the full 36-bit instruction word. From the word it takes two control bits. One asks for interrupts to be inhibited. The other asks for the operand address to go through appending.

From the current mode and those inputs the block produces several outputs. It flags instructions that are not allowed to execute and pulses an illegal-procedure fault for them. It drives an effective interrupt-inhibit level. It tells the address unit whether the instruction fetch and the operand fetch use the appending path (24-bit space) or the absolute path (18-bit space).

Fault entry and interrupt entry always put the block in Absolute mode. The block leaves Absolute mode only through a transfer instruction whose operand address was formed by appending. The new mode is then Master or Slave, chosen by a privilege input that is sampled with that transfer.

Top module: `pm_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `mode` is Absolute (2'b10), and `ill_fault` and `intr_inhibit` are 0. The mode encoding is Slave 2'b00, Master 2'b01 and Absolute 2'b10.
- R2: `ifetch_append` is 0 in Absolute mode and 1 in Slave and Master modes, in the same cycle.
- R3: Word bits are numbered with bit 0 as the most significant bit, so bit 29 is `instr_word[6]`. In Absolute mode, `opfetch_append` equals bit 29. In Slave and Master modes it is 1, whatever the value of bit 29.
- R4: A valid instruction with `instr_priv` set in Slave mode drives `exec_allow` to 0 in that cycle and raises `ill_fault` in the next cycle. In Master and Absolute modes, `exec_allow` equals `instr_valid`.
- R5: Bit 28 is `instr_word[7]`. A valid instruction with bit 28 set in Slave mode drives `exec_allow` to 0, raises `ill_fault` in the next cycle, and leaves `intr_inhibit` at 0.
- R6: In Master and Absolute modes, a valid instruction sets `intr_inhibit` to its bit 28 in the next cycle. After any valid instruction in Slave mode, `intr_inhibit` is 0. A cycle without a valid instruction leaves `intr_inhibit` unchanged.
- R7: When `fault_entry` or `intr_entry` is high, `mode` is Absolute in the next cycle, whatever the current mode.
- R8: In Absolute mode, a valid transfer with bit 29 set changes `mode` in the next cycle: to Master if `priv_master` is 1, to Slave if it is 0. A transfer with bit 29 clear, or any non-transfer, keeps Absolute mode.
- R9: If an entry request falls in the same cycle as a transfer that would leave Absolute mode, the entry wins and `mode` stays Absolute.
- R10: In Slave and Master modes without an entry request, `mode` does not change, transfers included.
- R11: `ill_fault` is high for exactly the cycle after each rejected instruction. After a cycle with no rejected instruction it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is executing this cycle |
| instr_priv | input | 1 | The instruction is privileged |
| instr_xfer | input | 1 | The instruction is a transfer |
| instr_word | input | 36 | Instruction word, bit 0 = MSB |
| fault_entry | input | 1 | Fault entry request |
| intr_entry | input | 1 | Interrupt entry request |
| priv_master | input | 1 | Target mode on leaving Absolute: 1 Master, 0 Slave |
| mode | output | 2 | Current mode |
| exec_allow | output | 1 | The current instruction may take effect |
| ill_fault | output | 1 | Illegal-procedure fault pulse |
| intr_inhibit | output | 1 | Effective interrupt inhibit |
| ifetch_append | output | 1 | Instruction fetch uses the appending path |
| opfetch_append | output | 1 | Operand fetch uses the appending path |

## Verification
Two things can arrive in the same cycle: an entry request (fault or interrupt) and a transfer in Absolute mode with bit 29 set, which would otherwise leave Absolute mode. The bench first places the controller in each of the three modes. It then applies every combination of the eight one-bit controls, including both entry inputs together with a qualifying transfer. It predicts the next mode with the entry taking priority and compares that prediction with `mode` one edge later. The same sweep also sets the privilege and inhibit requests in Slave mode while a transfer is present, and checks that the fault pulse and the inhibit level are right while the transfer leaves the mode unchanged.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    MODE_SLAVE  = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_ABS    = 2'b10
  } mode_e;

  // Decoded per-cycle instruction controls after field extraction.
  typedef struct packed {
    logic valid;
    logic priv;
    logic xfer;
    logic inhibit_req;
    logic append_sel;
  } instr_ctl_t;

endpackage

// File: rtl/pm_word_fields.sv
module pm_word_fields #(
  parameter int WORD_W  = 36,
  parameter int INH_BIT = 28,
  parameter int APP_BIT = 29,
  parameter bit MSB0    = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output logic              inhibit_req,
  output logic              append_sel
);

  // Convert the architectural bit number to a vector index.
  localparam int INH_IDX = MSB0 ? (WORD_W - 1 - INH_BIT) : INH_BIT;
  localparam int APP_IDX = MSB0 ? (WORD_W - 1 - APP_BIT) : APP_BIT;

  generate
    if (INH_IDX < 0 || INH_IDX >= WORD_W || APP_IDX < 0 || APP_IDX >= WORD_W) begin : g_bad
      assign inhibit_req = 1'b0;
      assign append_sel  = 1'b0;
    end else begin : g_ok
      assign inhibit_req = word[INH_IDX];
      assign append_sel  = word[APP_IDX];
    end
  endgenerate

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  instr_ctl_t ctl,
  input  logic       entry_req,
  input  logic       priv_master,
  output mode_e      mode_q
);

  mode_e mode_d;
  logic  leave_abs;
  logic  mode_en;

  // Exit from Absolute needs a transfer whose operand was appended.
  always_comb begin
    leave_abs = (mode_q == MODE_ABS) && ctl.valid && ctl.xfer && ctl.append_sel;
  end

  always_comb begin
    mode_d = mode_q;
    if (entry_req) begin
      mode_d = MODE_ABS;
    end else if (leave_abs) begin
      mode_d = priv_master ? MODE_MASTER : MODE_SLAVE;
    end
  end

  assign mode_en = entry_req || leave_abs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ABS;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assert_entry_forces_abs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> (mode_q == MODE_ABS));

  assert_exit_to_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_ABS) && ctl.valid && ctl.xfer && ctl.append_sel && !entry_req && priv_master)
      |=> (mode_q == MODE_MASTER));

  assert_exit_to_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_ABS) && ctl.valid && ctl.xfer && ctl.append_sel && !entry_req && !priv_master)
      |=> (mode_q == MODE_SLAVE));

  assert_entry_beats_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && ctl.valid && ctl.xfer && ctl.append_sel) |=> (mode_q == MODE_ABS));

  assert_user_modes_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != MODE_ABS) && !entry_req) |=> $stable(mode_q));

endmodule

// File: rtl/pm_priv_check.sv
module pm_priv_check
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  instr_ctl_t ctl,
  input  mode_e      mode_q,
  output logic       exec_allow,
  output logic       fault_q,
  output logic       inhibit_q
);

  logic is_slave;
  logic reject;
  logic fault_d;
  logic inhibit_d;
  logic inhibit_en;

  always_comb begin
    is_slave   = (mode_q == MODE_SLAVE);
    reject     = ctl.valid && is_slave && (ctl.priv || ctl.inhibit_req);
    exec_allow = ctl.valid && !reject;
  end

  always_comb begin
    fault_d    = reject;
    inhibit_en = ctl.valid;
    inhibit_d  = ctl.inhibit_req && !is_slave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else begin
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit_q <= 1'b0;
    end else if (inhibit_en) begin
      inhibit_q <= inhibit_d;
    end
  end

  assert_slave_priv_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.valid && (mode_q == MODE_SLAVE) && ctl.priv) |=> fault_q);

  assert_slave_inhibit_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.valid && (mode_q == MODE_SLAVE) && ctl.inhibit_req) |=> (fault_q && !inhibit_q));

  assert_inhibit_honoured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.valid && (mode_q != MODE_SLAVE)) |=> (inhibit_q == $past(ctl.inhibit_req)));

  assert_inhibit_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.valid |=> $stable(inhibit_q));

  assert_fault_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.valid || (mode_q != MODE_SLAVE)) |=> !fault_q);

endmodule

// File: rtl/pm_fetch_sel.sv
module pm_fetch_sel
  import pm_pkg::*;
(
  input  mode_e mode_q,
  input  logic  append_sel,
  output logic  ifetch_append,
  output logic  opfetch_append
);

  always_comb begin
    unique case (mode_q)
      MODE_SLAVE, MODE_MASTER: begin
        ifetch_append  = 1'b1;
        opfetch_append = 1'b1;
      end
      MODE_ABS: begin
        ifetch_append  = 1'b0;
        opfetch_append = append_sel;
      end
      default: begin
        ifetch_append  = 1'b0;
        opfetch_append = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
  import pm_pkg::*;
#(
  parameter int WORD_W  = 36,
  parameter int INH_BIT = 28,
  parameter int APP_BIT = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              instr_priv,
  input  logic              instr_xfer,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              fault_entry,
  input  logic              intr_entry,
  input  logic              priv_master,
  output logic [1:0]        mode,
  output logic              exec_allow,
  output logic              ill_fault,
  output logic              intr_inhibit,
  output logic              ifetch_append,
  output logic              opfetch_append
);

  instr_ctl_t ctl;
  mode_e      mode_q;
  logic       inh_bit;
  logic       app_bit;
  logic       entry_req;
  logic       unused_word_bits;

  assign unused_word_bits = ^instr_word;

  pm_word_fields #(
    .WORD_W  (WORD_W),
    .INH_BIT (INH_BIT),
    .APP_BIT (APP_BIT),
    .MSB0    (1'b1)
  ) u_fields (
    .word        (instr_word),
    .inhibit_req (inh_bit),
    .append_sel  (app_bit)
  );

  always_comb begin
    ctl.valid       = instr_valid;
    ctl.priv        = instr_priv;
    ctl.xfer        = instr_xfer;
    ctl.inhibit_req = inh_bit;
    ctl.append_sel  = app_bit;
    entry_req       = fault_entry || intr_entry;
  end

  pm_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .entry_req   (entry_req),
    .priv_master (priv_master),
    .mode_q      (mode_q)
  );

  pm_priv_check u_priv (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .mode_q     (mode_q),
    .exec_allow (exec_allow),
    .fault_q    (ill_fault),
    .inhibit_q  (intr_inhibit)
  );

  pm_fetch_sel u_fetch (
    .mode_q         (mode_q),
    .append_sel     (app_bit),
    .ifetch_append  (ifetch_append),
    .opfetch_append (opfetch_append)
  );

  assign mode = mode_q;

  assert_ifetch_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) == ifetch_append);

  assert_opfetch_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (opfetch_append == instr_word[WORD_W-1-APP_BIT]));

  assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

// File: tb/pm_mode_ctrl_tb.sv
module pm_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 100000;

  logic        clk;
  logic        rst_n;
  logic        instr_valid, instr_priv, instr_xfer;
  logic [35:0] instr_word;
  logic        fault_entry, intr_entry, priv_master;
  logic [1:0]  mode;
  logic        exec_allow, ill_fault, intr_inhibit, ifetch_append, opfetch_append;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  int exp_mode;
  bit exp_fault;
  bit exp_inh;

  pm_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_priv(instr_priv), .instr_xfer(instr_xfer),
    .instr_word(instr_word), .fault_entry(fault_entry), .intr_entry(intr_entry),
    .priv_master(priv_master), .mode(mode), .exec_allow(exec_allow),
    .ill_fault(ill_fault), .intr_inhibit(intr_inhibit),
    .ifetch_append(ifetch_append), .opfetch_append(opfetch_append)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d mode=%0d", req, what, act, expv, exp_mode);
    end
  endtask

  // One instruction cycle: drive at negedge, check combinational outputs,
  // then check registered outputs just after the rising edge.
  task automatic step(input bit v, input bit p, input bit x, input bit b28,
                      input bit b29, input bit f, input bit i, input bit pm,
                      input int salt);
    bit illegal;
    bit leave;
    int nm;
    logic [35:0] w;
    @(negedge clk);
    w = {36{salt[0]}} ^ {4'h9, 32'h5A3C_96E1} ^ {30'd0, salt[5:0]};
    w[7] = b28;
    w[6] = b29;
    instr_valid = v; instr_priv = p; instr_xfer = x; instr_word = w;
    fault_entry = f; intr_entry = i; priv_master = pm;
    #1;
    illegal = v && (exp_mode == 0) && (p || b28);
    chk("R2", "ifetch_append", int'(ifetch_append), (exp_mode != 2) ? 1 : 0);
    chk("R3", "opfetch_append", int'(opfetch_append), ((exp_mode != 2) || b29) ? 1 : 0);
    chk(b28 && !p ? "R5" : "R4", "exec_allow", int'(exec_allow), (v && !illegal) ? 1 : 0);
    leave = (exp_mode == 2) && v && x && b29;
    if (f || i) nm = 2;
    else if (leave) nm = pm ? 1 : 0;
    else nm = exp_mode;
    @(posedge clk);
    #1;
    if ((f || i) && leave) chk("R9", "mode", int'(mode), nm);
    else if (f || i)       chk("R7", "mode", int'(mode), nm);
    else if (exp_mode == 2) chk("R8", "mode", int'(mode), nm);
    else                   chk("R10", "mode", int'(mode), nm);
    if (v && exp_mode == 0 && p) chk("R4", "ill_fault", int'(ill_fault), 1);
    else if (illegal)            chk("R5", "ill_fault", int'(ill_fault), 1);
    else                         chk("R11", "ill_fault", int'(ill_fault), 0);
    if (v) exp_inh = b28 && (exp_mode != 0);
    chk((v && exp_mode == 0 && b28) ? "R5" : "R6", "intr_inhibit", int'(intr_inhibit), int'(exp_inh));
    exp_fault = illegal;
    exp_mode  = nm;
  endtask

  task automatic go_mode(input int m);
    step(0, 0, 0, 0, 0, 1, 0, 0, 3);
    if (m != 2) step(1, 0, 1, 0, 1, 0, 0, (m == 1), 4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WDOG_LIMIT);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 0; instr_priv = 0; instr_xfer = 0; instr_word = '0;
    fault_entry = 0; intr_entry = 0; priv_master = 0;
    exp_mode = 2; exp_fault = 0; exp_inh = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mode in reset", int'(mode), 2);
    chk("R1", "ill_fault in reset", int'(ill_fault), 0);
    chk("R1", "intr_inhibit in reset", int'(intr_inhibit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "mode after release", int'(mode), 2);
    chk("R1", "ill_fault after release", int'(ill_fault), 0);
    chk("R1", "intr_inhibit after release", int'(intr_inhibit), 0);

    // Abs: non-appended transfer keeps Absolute (R8).
    step(1, 0, 1, 0, 0, 0, 0, 1, 1);
    // Inhibit set in Abs, then held across idle cycles (R6).
    step(1, 0, 0, 1, 0, 0, 0, 0, 2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 7);
    chk("R6", "inhibit held while idle", int'(intr_inhibit), 1);

    // Exhaustive sweep from each mode over all eight control bits.
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 256; k++) begin
        go_mode(m);
        chk("R10", "setup mode", exp_mode, m);
        step(k[0], k[1], k[2], k[3], k[4], k[5], k[6], k[7], k);
        // Follow-up idle cycle checks the fault pulse has ended (R11).
        step(0, 0, 0, 0, 0, 0, 0, 0, k + 11);
      end
    end

    // Back-to-back rejected instructions in Slave keep the pulse high (R11).
    go_mode(0);
    step(1, 1, 0, 0, 0, 0, 0, 0, 21);
    step(1, 0, 0, 1, 0, 0, 0, 0, 22);
    step(1, 0, 0, 0, 0, 0, 0, 0, 23);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule